// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Slice

This block is an arithmetic slice built from four 18x18 multipliers. A static element-kind parameter chooses how the four products are combined. In multiply form each lane returns its own product. In multiply-accumulate form lanes 0 and 1 feed two 52-bit running totals. In pairwise form the slice returns two sums or differences of two products each. In summation form all four products are folded into one result. The signedness of the operands and the add/subtract direction of each adder can be changed from cycle to cycle without reconfiguring the slice.

Optional registers can sit at three points: at the operands, after the multipliers and at the result. Each point is switched on by its own parameter. A valid flag travels through the same registers, so the valid output marks the cycle in which a result belongs to a given input. One clock enable freezes every register in the slice. The operand registers can also act as a delay line: lane 0 loads from a shift-in port, each higher lane loads from the lane below it, and lane 3 is presented on shift-out ports. Chaining slices this way builds tapped delay lines for filters.

Top module: `dsp_slice`

## Requirements
- R1: In multiply form (ELEM = EL_MULT), each result lane k (bits 52k+51..52k) equals A lane k times B lane k. The result is sign-extended to 52 bits when signed and zero-extended when unsigned. Operand lane k sits at bits 18k+17..18k.
- R2: `signed_op` = 1 treats all eight operands as two's complement and 0 treats them all as unsigned. It may change on any cycle and travels with the operands it was sampled with.
- R3: In pairwise form (EL_MADD), result lane 0 is P0+P1, or P0-P1 when `sub_sel[0]`=1. Result lane 1 is P2+P3, or P2-P3 when `sub_sel[1]`=1. Lanes 2 and 3 are zero.
- R4: In summation form (EL_MSUM), result lane 0 is (P0 op0 P1) op2 (P2 op1 P3). Each opN is subtraction when `sub_sel[N]`=1 and addition otherwise. Lanes 1 to 3 are zero.
- R5: In accumulate form (EL_MAC), total j (j = 0, 1) becomes total j + Pj, or total j - Pj when `sub_sel[j]`=1. The update happens only on a cycle whose sample is valid. Totals wrap modulo 2^52 and appear on result lanes 0 and 1, with lanes 2 and 3 zero.
- R6: When `acc_clr[j]`=1 on a valid sample, total j discards its old value and becomes +Pj, or -Pj when `sub_sel[j]`=1.
- R7: `vld_out` follows `vld_in` by exactly IN_REG+MID_REG+OUT_REG enabled cycles, with the result stage counted as present in accumulate form. The matching result is on `res` in that same cycle.
- R8: With the operand stage present and `shift_sel`=1, lane 0 of A and B loads from `a_shift_in`/`b_shift_in` and lane k loads from lane k-1. `a_shift_out`/`b_shift_out` show the lane 3 operand registers.
- R9: While `ce`=0, no register changes: results, totals, the valid pipeline and shift-out stay as they were.
- R10: While `rst_n` is low, every result lane, `vld_out` and both shift-out ports are zero, and accumulator totals restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for every register |
| vld_in | input | 1 | Marks the operand sample as valid |
| shift_sel | input | 1 | 1: operands from the shift chain, 0: parallel ports |
| signed_op | input | 1 | 1: signed operands, 0: unsigned |
| sub_sel | input | 3 | Per-adder subtract select |
| acc_clr | input | 2 | Per-total accumulator clear |
| a_in | input | 72 | A operands, four 18-bit lanes |
| b_in | input | 72 | B operands, four 18-bit lanes |
| a_shift_in | input | 18 | A operand from the neighbouring slice |
| b_shift_in | input | 18 | B operand from the neighbouring slice |
| res | output | 208 | Four 52-bit result lanes |
| vld_out | output | 1 | Result valid |
| a_shift_out | output | 18 | A lane 3 operand register, to the next slice |
| b_shift_out | output | 18 | B lane 3 operand register, to the next slice |

## Verification
Two pairs of functions are provoked in the same cycle and judged against a model of the requirements. In the first pair, a clear and a subtract land together on the same total: a vector carries `acc_clr[0]`=1 with `sub_sel[0]`=1, and the total must become the negated product, not the old value minus the product. In the second pair, a valid sample arrives while the clock enable is low: it must be neither accumulated nor carried to `vld_out`, and every result lane must hold its previous value. A shift-chain run additionally joins delay-line loading and a valid pulse, and checks the per-lane products at the point where the pulse emerges.

// File: rtl/dsp_slice_pkg.sv
package dsp_slice_pkg;

    typedef enum logic [1:0] {
        EL_MULT = 2'd0,
        EL_MAC  = 2'd1,
        EL_MADD = 2'd2,
        EL_MSUM = 2'd3
    } elem_e;

    // the combining network is built for exactly four product lanes
    localparam int LANES = 4;
    // number of per-adder subtract controls and per-total clears
    localparam int SUBW  = 3;
    localparam int CLRW  = 2;
    // control bundle carried with the operands: {vld, clr, sub}
    localparam int CTLW  = 1 + CLRW + SUBW;

endpackage

// File: rtl/dsp_opt_reg.sv
module dsp_opt_reg #(
    parameter int W  = 1,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (EN) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (ce) begin
                q <= d;
            end
        end
    end else begin : g_wire
        logic unused_pins;
        assign unused_pins = ^{clk, rst_n, ce};
        assign q = d;
    end

endmodule

// File: rtl/dsp_operand_bank.sv
module dsp_operand_bank
    import dsp_slice_pkg::*;
#(
    parameter int OPW    = 18,
    parameter bit IN_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 shift_sel,
    input  logic                 signed_op,
    input  logic [LANES*OPW-1:0] a_in,
    input  logic [LANES*OPW-1:0] b_in,
    input  logic [OPW-1:0]       a_sh_in,
    input  logic [OPW-1:0]       b_sh_in,
    output logic [LANES*OPW-1:0] a_q,
    output logic [LANES*OPW-1:0] b_q,
    output logic                 sgn_q,
    output logic [OPW-1:0]       a_sh_out,
    output logic [OPW-1:0]       b_sh_out
);

    localparam int PAIRW = 2 * OPW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OPW-1:0]   a_src;
        logic [OPW-1:0]   b_src;
        logic [PAIRW-1:0] pair_d;
        logic [PAIRW-1:0] pair_q;

        if (k == 0) begin : g_head
            assign a_src = a_sh_in;
            assign b_src = b_sh_in;
        end else begin : g_link
            assign a_src = a_q[(k-1)*OPW +: OPW];
            assign b_src = b_q[(k-1)*OPW +: OPW];
        end

        always_comb begin
            if (shift_sel) begin
                pair_d = {b_src, a_src};
            end else begin
                pair_d = {b_in[k*OPW +: OPW], a_in[k*OPW +: OPW]};
            end
        end

        dsp_opt_reg #(.W(PAIRW), .EN(IN_REG)) u_opnd (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce),
            .d     (pair_d),
            .q     (pair_q)
        );

        assign a_q[k*OPW +: OPW] = pair_q[OPW-1:0];
        assign b_q[k*OPW +: OPW] = pair_q[PAIRW-1:OPW];
    end

    dsp_opt_reg #(.W(1), .EN(IN_REG)) u_sgn (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     (signed_op),
        .q     (sgn_q)
    );

    assign a_sh_out = a_q[(LANES-1)*OPW +: OPW];
    assign b_sh_out = b_q[(LANES-1)*OPW +: OPW];

endmodule

// File: rtl/dsp_mul_array.sv
module dsp_mul_array
    import dsp_slice_pkg::*;
#(
    parameter int OPW     = 18,
    parameter int ACCW    = 52,
    parameter bit MID_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  sgn,
    input  logic [LANES*OPW-1:0]  a_q,
    input  logic [LANES*OPW-1:0]  b_q,
    output logic [LANES*ACCW-1:0] prod
);

    // operands widened by one bit so one signed multiplier covers both modes
    localparam int XW   = OPW + 1;
    localparam int PW   = 2 * XW;
    localparam int PADW = ACCW - PW;

    for (genvar k = 0; k < LANES; k++) begin : g_mul
        logic signed [XW-1:0] ax;
        logic signed [XW-1:0] bx;
        logic signed [PW-1:0] pr;
        logic [ACCW-1:0]      pe;

        assign ax = {sgn & a_q[k*OPW + OPW - 1], a_q[k*OPW +: OPW]};
        assign bx = {sgn & b_q[k*OPW + OPW - 1], b_q[k*OPW +: OPW]};
        assign pr = ax * bx;
        assign pe = {{PADW{pr[PW-1]}}, pr};

        dsp_opt_reg #(.W(ACCW), .EN(MID_REG)) u_mid (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce),
            .d     (pe),
            .q     (prod[k*ACCW +: ACCW])
        );
    end

endmodule

// File: rtl/dsp_combiner.sv
module dsp_combiner
    import dsp_slice_pkg::*;
#(
    parameter elem_e ELEM    = EL_MULT,
    parameter int    ACCW    = 52,
    parameter bit    OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic [LANES*ACCW-1:0] prod,
    input  logic                  vld,
    input  logic [CLRW-1:0]       clr,
    input  logic [SUBW-1:0]       sub,
    output logic [LANES*ACCW-1:0] res,
    output logic                  vld_out
);

    localparam int RW = LANES * ACCW;

    function automatic logic [ACCW-1:0] addsub(
        input logic [ACCW-1:0] x,
        input logic [ACCW-1:0] y,
        input logic            s
    );
        return s ? (x - y) : (x + y);
    endfunction

    logic [ACCW-1:0] p [LANES];
    for (genvar k = 0; k < LANES; k++) begin : g_split
        assign p[k] = prod[k*ACCW +: ACCW];
    end

    if (ELEM == EL_MAC) begin : g_mac
        // the running totals double as the result stage
        for (genvar j = 0; j < CLRW; j++) begin : g_tot
            logic [ACCW-1:0] acc_r;
            logic [ACCW-1:0] base;

            assign base = clr[j] ? '0 : acc_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_r <= '0;
                end else if (ce && vld) begin
                    acc_r <= addsub(base, p[j], sub[j]);
                end
            end

            assign res[j*ACCW +: ACCW] = acc_r;
        end

        logic vld_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
            end else if (ce) begin
                vld_r <= vld;
            end
        end

        assign res[RW-1:CLRW*ACCW] = '0;
        assign vld_out             = vld_r;

        logic unused_mac;
        assign unused_mac = ^{p[2], p[3], sub[2]};
    end else begin : g_cmb
        logic [RW-1:0] cmb;

        always_comb begin
            cmb = '0;
            unique case (ELEM)
                EL_MADD: begin
                    cmb[0 +: ACCW]    = addsub(p[0], p[1], sub[0]);
                    cmb[ACCW +: ACCW] = addsub(p[2], p[3], sub[1]);
                end
                EL_MSUM: begin
                    cmb[0 +: ACCW] = addsub(addsub(p[0], p[1], sub[0]),
                                            addsub(p[2], p[3], sub[1]),
                                            sub[2]);
                end
                default: begin
                    cmb = prod;
                end
            endcase
        end

        dsp_opt_reg #(.W(RW + 1), .EN(OUT_REG)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .ce    (ce),
            .d     ({vld, cmb}),
            .q     ({vld_out, res})
        );

        logic unused_cmb;
        assign unused_cmb = ^{clr, sub};
    end

endmodule

// File: rtl/dsp_slice.sv
module dsp_slice
    import dsp_slice_pkg::*;
#(
    parameter elem_e ELEM    = EL_MULT,
    parameter bit    IN_REG  = 1'b1,
    parameter bit    MID_REG = 1'b1,
    parameter bit    OUT_REG = 1'b1,
    parameter int    OPW     = 18,
    parameter int    ACCW    = 52
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  vld_in,
    input  logic                  shift_sel,
    input  logic                  signed_op,
    input  logic [SUBW-1:0]       sub_sel,
    input  logic [CLRW-1:0]       acc_clr,
    input  logic [LANES*OPW-1:0]  a_in,
    input  logic [LANES*OPW-1:0]  b_in,
    input  logic [OPW-1:0]        a_shift_in,
    input  logic [OPW-1:0]        b_shift_in,
    output logic [LANES*ACCW-1:0] res,
    output logic                  vld_out,
    output logic [OPW-1:0]        a_shift_out,
    output logic [OPW-1:0]        b_shift_out
);

    logic [LANES*OPW-1:0]  a_q;
    logic [LANES*OPW-1:0]  b_q;
    logic                  sgn_q;
    logic [LANES*ACCW-1:0] prod_m;
    logic [CTLW-1:0]       ctl_i;
    logic [CTLW-1:0]       ctl_m;

    // operand stage with the inter-slice delay chain
    dsp_operand_bank #(.OPW(OPW), .IN_REG(IN_REG)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .shift_sel (shift_sel),
        .signed_op (signed_op),
        .a_in      (a_in),
        .b_in      (b_in),
        .a_sh_in   (a_shift_in),
        .b_sh_in   (b_shift_in),
        .a_q       (a_q),
        .b_q       (b_q),
        .sgn_q     (sgn_q),
        .a_sh_out  (a_shift_out),
        .b_sh_out  (b_shift_out)
    );

    // controls ride alongside the operands and products
    dsp_opt_reg #(.W(CTLW), .EN(IN_REG)) u_ctl_in (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     ({vld_in, acc_clr, sub_sel}),
        .q     (ctl_i)
    );

    dsp_opt_reg #(.W(CTLW), .EN(MID_REG)) u_ctl_mid (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .d     (ctl_i),
        .q     (ctl_m)
    );

    dsp_mul_array #(.OPW(OPW), .ACCW(ACCW), .MID_REG(MID_REG)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .sgn   (sgn_q),
        .a_q   (a_q),
        .b_q   (b_q),
        .prod  (prod_m)
    );

    dsp_combiner #(.ELEM(ELEM), .ACCW(ACCW), .OUT_REG(OUT_REG)) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .prod    (prod_m),
        .vld     (ctl_m[CTLW-1]),
        .clr     (ctl_m[SUBW +: CLRW]),
        .sub     (ctl_m[SUBW-1:0]),
        .res     (res),
        .vld_out (vld_out)
    );

endmodule

// File: rtl/dsp_slice_chk.sv
module dsp_slice_chk
    import dsp_slice_pkg::*;
#(
    parameter elem_e ELEM    = EL_MULT,
    parameter bit    IN_REG  = 1'b1,
    parameter bit    MID_REG = 1'b1,
    parameter bit    OUT_REG = 1'b1,
    parameter int    OPW     = 18,
    parameter int    ACCW    = 52
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce,
    input logic                  shift_sel,
    input logic [LANES*ACCW-1:0] res,
    input logic                  vld_out,
    input logic [OPW-1:0]        a_shift_out,
    input logic [LANES*OPW-1:0]  a_q,
    input logic [LANES*ACCW-1:0] prod_m,
    input logic [CTLW-1:0]       ctl_m
);

    localparam int LAT = int'(IN_REG) + int'(MID_REG) +
                         ((ELEM == EL_MAC) ? 1 : int'(OUT_REG));

    logic unused_chk;
    assign unused_chk = ^{res, a_q, prod_m, ctl_m, shift_sel, a_shift_out};

    if (IN_REG) begin : g_in
        // R9
        ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ce |=> ($stable(res) && $stable(vld_out)));

        // R8
        shift_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce && shift_sel) |=> (a_shift_out == $past(a_q[2*OPW +: OPW])));
    end

    if (LAT > 0) begin : g_lat
        // R7
        vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(vld_out) |-> $past(ce));
    end

    if (ELEM == EL_MULT && OUT_REG) begin : g_mult
        // R1
        mult_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ce |=> (res[ACCW +: ACCW] == $past(prod_m[ACCW +: ACCW])));
    end

    if (ELEM == EL_MAC) begin : g_mac
        // R5
        acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce && ctl_m[CTLW-1] && !ctl_m[SUBW] && !ctl_m[0])
            |=> (res[0 +: ACCW] == $past(res[0 +: ACCW] + prod_m[0 +: ACCW])));

        // R6
        acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ce && ctl_m[CTLW-1] && ctl_m[SUBW] && !ctl_m[0])
            |=> (res[0 +: ACCW] == $past(prod_m[0 +: ACCW])));
    end

endmodule

bind dsp_slice dsp_slice_chk #(
    .ELEM    (ELEM),
    .IN_REG  (IN_REG),
    .MID_REG (MID_REG),
    .OUT_REG (OUT_REG),
    .OPW     (OPW),
    .ACCW    (ACCW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce          (ce),
    .shift_sel   (shift_sel),
    .res         (res),
    .vld_out     (vld_out),
    .a_shift_out (a_shift_out),
    .a_q         (a_q),
    .prod_m      (prod_m),
    .ctl_m       (ctl_m)
);

// File: tb/dsp_slice_tb.sv
module dsp_slice_tb;
    import dsp_slice_pkg::*;

    localparam int NV = 6;

    // stimulus table: lane 0 is the rightmost field
    localparam logic [71:0] VA [NV] = '{
        {18'h00004, 18'h00003, 18'h00002, 18'h00001},
        {18'h3FFFF, 18'h00002, 18'h3FFFE, 18'h00064},
        {18'h3FFFF, 18'h00002, 18'h3FFFE, 18'h00064},
        {18'h20000, 18'h20000, 18'h1FFFF, 18'h3FFFF},
        {18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF},
        {18'h1F000, 18'h3F00F, 18'h00FFF, 18'h2ABCD}
    };
    localparam logic [71:0] VB [NV] = '{
        {18'h00008, 18'h00007, 18'h00006, 18'h00005},
        {18'h00005, 18'h3FFFD, 18'h00007, 18'h00003},
        {18'h00005, 18'h3FFFD, 18'h00007, 18'h00003},
        {18'h20000, 18'h1FFFF, 18'h1FFFF, 18'h3FFFF},
        {18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF},
        {18'h3FFFF, 18'h12345, 18'h3C000, 18'h0000A}
    };
    localparam logic       VS   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [2:0] VSUB [NV] = '{3'b000, 3'b011, 3'b100, 3'b101, 3'b111, 3'b010};
    localparam logic [1:0] VCLR [NV] = '{2'b11, 2'b00, 2'b00, 2'b01, 2'b10, 2'b00};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce = 1'b1;
    logic         vld_in = 1'b0;
    logic         shift_sel = 1'b0;
    logic         signed_op = 1'b0;
    logic [2:0]   sub_sel = '0;
    logic [1:0]   acc_clr = '0;
    logic [71:0]  a_in = '0;
    logic [71:0]  b_in = '0;
    logic [17:0]  a_shift_in = '0;
    logic [17:0]  b_shift_in = '0;

    logic [207:0] res_d, res_c, res_a, res_s;
    logic         vld_d, vld_c, vld_a, vld_s;
    logic [17:0]  aso_d, bso_d, aso_c, bso_c, aso_a, bso_a, aso_s, bso_s;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    // multiply form, all three stages: latency 3
    dsp_slice #(.ELEM(EL_MULT), .IN_REG(1'b1), .MID_REG(1'b1), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .vld_in(vld_in), .shift_sel(shift_sel),
        .signed_op(signed_op), .sub_sel(sub_sel), .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in),
        .a_shift_in(a_shift_in), .b_shift_in(b_shift_in), .res(res_d), .vld_out(vld_d),
        .a_shift_out(aso_d), .b_shift_out(bso_d));

    // accumulate form, operand stage only plus totals: latency 2
    dsp_slice #(.ELEM(EL_MAC), .IN_REG(1'b1), .MID_REG(1'b0), .OUT_REG(1'b0)) u_mac (
        .clk(clk), .rst_n(rst_n), .ce(ce), .vld_in(vld_in), .shift_sel(shift_sel),
        .signed_op(signed_op), .sub_sel(sub_sel), .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in),
        .a_shift_in(a_shift_in), .b_shift_in(b_shift_in), .res(res_c), .vld_out(vld_c),
        .a_shift_out(aso_c), .b_shift_out(bso_c));

    // pairwise form, operand and result stages: latency 2
    dsp_slice #(.ELEM(EL_MADD), .IN_REG(1'b1), .MID_REG(1'b0), .OUT_REG(1'b1)) u_madd (
        .clk(clk), .rst_n(rst_n), .ce(ce), .vld_in(vld_in), .shift_sel(shift_sel),
        .signed_op(signed_op), .sub_sel(sub_sel), .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in),
        .a_shift_in(a_shift_in), .b_shift_in(b_shift_in), .res(res_a), .vld_out(vld_a),
        .a_shift_out(aso_a), .b_shift_out(bso_a));

    // summation form, operand and intermediate stages: latency 2
    dsp_slice #(.ELEM(EL_MSUM), .IN_REG(1'b1), .MID_REG(1'b1), .OUT_REG(1'b0)) u_sum (
        .clk(clk), .rst_n(rst_n), .ce(ce), .vld_in(vld_in), .shift_sel(shift_sel),
        .signed_op(signed_op), .sub_sel(sub_sel), .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in),
        .a_shift_in(a_shift_in), .b_shift_in(b_shift_in), .res(res_s), .vld_out(vld_s),
        .a_shift_out(aso_s), .b_shift_out(bso_s));

    logic [51:0] pk    [4];
    logic [51:0] e_mul [4];
    logic [51:0] e_mad [4];
    logic [51:0] e_sum [4];
    logic [51:0] acc   [2];

    function automatic logic [51:0] mdl_prod(input logic [17:0] a, input logic [17:0] b,
                                             input logic sgn);
        longint x, y;
        x = sgn ? longint'($signed(a)) : longint'({46'b0, a});
        y = sgn ? longint'($signed(b)) : longint'({46'b0, b});
        return 52'(x * y);
    endfunction

    function automatic logic [51:0] mdl_as(input logic [51:0] x, input logic [51:0] y,
                                           input logic s);
        return s ? 52'(x - y) : 52'(x + y);
    endfunction

    task automatic chk(input string req, input logic [51:0] got, input logic [51:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_reset_state(input string req);
        for (int k = 0; k < 4; k++) begin
            chk(req, res_d[k*52 +: 52], '0);
            chk(req, res_c[k*52 +: 52], '0);
            chk(req, res_a[k*52 +: 52], '0);
            chk(req, res_s[k*52 +: 52], '0);
        end
        chk(req, {48'b0, vld_d, vld_c, vld_a, vld_s}, '0);
        chk(req, {16'b0, aso_d, bso_d}, '0);
    endtask

    task automatic build_model(input int v);
        for (int k = 0; k < 4; k++)
            pk[k] = mdl_prod(VA[v][k*18 +: 18], VB[v][k*18 +: 18], VS[v]);
        for (int k = 0; k < 4; k++) e_mul[k] = pk[k];
        e_mad[0] = mdl_as(pk[0], pk[1], VSUB[v][0]);
        e_mad[1] = mdl_as(pk[2], pk[3], VSUB[v][1]);
        e_mad[2] = '0;
        e_mad[3] = '0;
        e_sum[0] = mdl_as(mdl_as(pk[0], pk[1], VSUB[v][0]),
                          mdl_as(pk[2], pk[3], VSUB[v][1]), VSUB[v][2]);
        e_sum[1] = '0;
        e_sum[2] = '0;
        e_sum[3] = '0;
        for (int j = 0; j < 2; j++)
            acc[j] = mdl_as(VCLR[v][j] ? 52'd0 : acc[j], pk[j], VSUB[v][j]);
    endtask

    logic [207:0] sv_d, sv_c;
    logic [17:0]  sa [4];
    logic [17:0]  sb [4];

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        acc[0] = '0;
        acc[1] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_reset_state("R10 initial reset");
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: one valid pulse per vector, every output checked on each edge
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            a_in      = VA[v];
            b_in      = VB[v];
            signed_op = VS[v];
            sub_sel   = VSUB[v];
            acc_clr   = VCLR[v];
            vld_in    = 1'b1;
            build_model(v);
            for (int c = 1; c <= 4; c++) begin
                @(posedge clk);
                #1;
                if (c == 1) vld_in = 1'b0;
                chk("R7 mult valid",  {51'b0, vld_d}, {51'b0, c == 3});
                chk("R7 mac valid",   {51'b0, vld_c}, {51'b0, c == 2});
                chk("R7 madd valid",  {51'b0, vld_a}, {51'b0, c == 2});
                chk("R7 msum valid",  {51'b0, vld_s}, {51'b0, c == 2});
                if (c == 3)
                    for (int k = 0; k < 4; k++)
                        chk("R1 R2 mult lane", res_d[k*52 +: 52], e_mul[k]);
                if (c == 2) begin
                    chk(VCLR[v][0] ? "R6 mac clear lane0" : "R5 mac lane0", res_c[0 +: 52], acc[0]);
                    chk(VCLR[v][1] ? "R6 mac clear lane1" : "R5 mac lane1", res_c[52 +: 52], acc[1]);
                    chk("R5 mac lane2", res_c[104 +: 52], '0);
                    chk("R5 mac lane3", res_c[156 +: 52], '0);
                    for (int k = 0; k < 4; k++) begin
                        chk("R3 madd lane", res_a[k*52 +: 52], e_mad[k]);
                        chk("R4 msum lane", res_s[k*52 +: 52], e_sum[k]);
                    end
                end
            end
        end

        // clock enable low while a valid sample is presented
        @(negedge clk);
        sv_d   = res_d;
        sv_c   = res_c;
        ce     = 1'b0;
        vld_in = 1'b1;
        a_in   = ~a_in;
        acc_clr = 2'b11;
        for (int c = 1; c <= 3; c++) begin
            @(posedge clk);
            #1;
            for (int k = 0; k < 4; k++) begin
                chk("R9 hold mult", res_d[k*52 +: 52], sv_d[k*52 +: 52]);
                chk("R9 hold mac",  res_c[k*52 +: 52], sv_c[k*52 +: 52]);
            end
            chk("R9 hold valid", {50'b0, vld_d, vld_c}, '0);
        end
        @(negedge clk);
        vld_in  = 1'b0;
        acc_clr = 2'b00;
        ce      = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R9 mac totals survive", res_c[0 +: 52], acc[0]);
        chk("R9 mac totals survive", res_c[52 +: 52], acc[1]);

        // reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_reset_state("R10 mid-run reset");
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        acc[0] = '0;
        acc[1] = '0;

        // shift chain: four pushes, valid on the last one
        sa[0] = 18'h00011; sa[1] = 18'h3FFF0; sa[2] = 18'h00123; sa[3] = 18'h20000;
        sb[0] = 18'h00005; sb[1] = 18'h00007; sb[2] = 18'h3FFFF; sb[3] = 18'h00002;
        signed_op = 1'b1;
        sub_sel   = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            shift_sel  = 1'b1;
            a_shift_in = sa[i];
            b_shift_in = sb[i];
            vld_in     = (i == 3);
        end
        @(posedge clk);
        #1;
        vld_in = 1'b0;
        chk("R8 a shift out", {34'b0, aso_d}, {34'b0, sa[0]});
        chk("R8 b shift out", {34'b0, bso_d}, {34'b0, sb[0]});
        @(posedge clk);
        #1;
        chk("R7 shift valid early", {51'b0, vld_d}, '0);
        @(posedge clk);
        #1;
        chk("R7 shift valid", {51'b0, vld_d}, 52'd1);
        for (int k = 0; k < 4; k++)
            chk("R8 delay line lane", res_d[k*52 +: 52], mdl_prod(sa[3-k], sb[3-k], 1'b1));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule